// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block is the clock master of a three-wire stereo audio link. From its system clock it derives a bit clock with a programmable even divider. It also drives a frame clock and a serial data line. Each frame lasts 64 bit-clock periods and carries one left and one right PCM word. Words are accepted in parallel pairs through a valid/ready handshake, one pair per frame.

Three framings share one slot counter: right-justified, I2S and DSP-early. They differ in frame-clock shape and in where each word sits inside the frame. The framing and the word length (16, 20, 24 or 32 bits) are taken from their inputs only at a frame boundary. Data and frame clock change only on falling bit-clock edges, so a receiver can sample on rising edges. If no pair is offered when a frame begins, the last pair is sent again and an underrun flag marks that frame.

Slot k of a frame is the bit period that begins at the k-th falling bit-clock edge of that frame, counting from 0. The frame begins at slot 0.

Top module: `aud_ser_tx`

## Requirements
- R1: `bclk` is low after reset and toggles every `div_half` system clocks (a value of 0 acts as 1), so one bit period is 2*`div_half` cycles. A frame is 64 bit periods.
- R2: `sdata` and `lrclk` change only at falling edges of `bclk`. They are stable while `bclk` is high.
- R3: I2S framing (`fmt_sel` 1, and 3 as an alias): `lrclk` is low in slots 0..31 and high in slots 32..63. The left word is sent MSB first in slots 1..n, and the right word in slots 33..32+n.
- R4: Right-justified framing (`fmt_sel` 0): `lrclk` is the same as in I2S. The left word is sent MSB first so that its LSB lands in slot 31. The right word's LSB lands in slot 63.
- R5: DSP-early framing (`fmt_sel` 2): `lrclk` is high in slot 0 only. The left word is sent MSB first in slots 1..n, and the right word follows with no gap in slots n+1..2n.
- R6: `wlen_sel` 0/1/2/3 selects n = 16/20/24/32. A word is taken from bits n-1..0 of its input, and higher input bits have no effect on `sdata`.
- R7: Every slot outside the active words (and outside the R8 slot) drives `sdata` low.
- R8: In I2S or DSP-early framing with n = 32, the right LSB falls past the frame. It is sent in slot 0 of the next frame, taken from the previous frame's right word. Otherwise slot 0 is low.
- R9: `in_ready` is a one-cycle pulse at the system clock edge that starts slot 0. A pair, `fmt_sel` and `wlen_sel` are all taken on that edge, and changes to them at other times do not affect the frame in progress.
- R10: If `in_valid` is low when `in_ready` pulses, the previous pair is sent again and `underrun` is high for that frame. `underrun` is low for a frame whose pair was accepted.
- R11: After reset, `sdata`, `underrun` and `in_ready` are low, `bclk` is low and `lrclk` is high. The block is then in slot 63 of an idle frame with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_half | input | DIV_W | System clocks per bit-clock half period |
| fmt_sel | input | 2 | Framing: 0 right-justified, 1 I2S, 2 DSP-early, 3 I2S |
| wlen_sel | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| in_valid | input | 1 | A sample pair is offered |
| in_left | input | 32 | Left sample, word in low n bits |
| in_right | input | 32 | Right sample, word in low n bits |
| in_ready | output | 1 | Pair taken this cycle (frame start) |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| sdata | output | 1 | Serial data, MSB first |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
The assertions take `div_half` to be held constant once reset is released. A change mid-period would shorten one bit period, though the stability and frame-boundary properties would still hold. They also take the sampled `in_valid` at the frame-start edge to be the one that decides the underrun flag. The stimulus fixes `div_half` at 2 for the whole run. It changes `fmt_sel`, `wlen_sel` and the data only at the falling system-clock edge just after each accepted frame start, which is in the middle of the frame being sent. It sweeps every framing and word-length pair, including the I2S alias and frames with no pair offered.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int WMAX   = 32;
  localparam int SLOTS  = 64;
  localparam int HALF   = SLOTS / 2;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int POS_W  = SLOT_W + 1;
  localparam int IDX_W  = $clog2(WMAX);

  typedef enum logic [1:0] {
    FMT_RJ      = 2'd0,
    FMT_I2S     = 2'd1,
    FMT_DSP     = 2'd2,
    FMT_I2S_ALT = 2'd3
  } fmt_e;

  typedef logic [POS_W-1:0] pos_t;
  typedef logic [IDX_W-1:0] idx_t;

  // word length in bits from the select code
  function automatic pos_t wl_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return pos_t'(16);
      2'd1:    return pos_t'(20);
      2'd2:    return pos_t'(24);
      default: return pos_t'(WMAX);
    endcase
  endfunction

  // first slot of the left word
  function automatic pos_t left_start(input fmt_e m, input pos_t n);
    return (m == FMT_RJ) ? pos_t'(HALF) - n : pos_t'(1);
  endfunction

  // first slot of the right word
  function automatic pos_t right_start(input fmt_e m, input pos_t n);
    case (m)
      FMT_RJ:  return pos_t'(SLOTS) - n;
      FMT_DSP: return pos_t'(1) + n;
      default: return pos_t'(HALF + 1);
    endcase
  endfunction

  // bit sent at offset off (0 = MSB) of an n-bit word held in w[n-1:0]
  function automatic logic word_bit(input logic [WMAX-1:0] w, input pos_t n, input pos_t off);
    idx_t idx;
    idx = idx_t'(n - off - pos_t'(1));
    return w[idx];
  endfunction
endpackage

// File: rtl/aud_bclk_gen.sv
module aud_bclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  output logic             bclk,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             tick;

  assign lim      = (div_half == '0) ? DIV_W'(1) : div_half;
  assign tick     = ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
  assign fall_evt = tick & bclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  AST_BCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(bclk)); // R1
endmodule

// File: rtl/aud_slot_ctr.sv
module aud_slot_ctr
  import aud_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_evt,
  output logic [SLOT_W-1:0] slot,
  output logic              frame_start
);
  assign frame_start = fall_evt && (slot == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        slot <= SLOT_W'(SLOTS - 1);
    else if (fall_evt) slot <= slot + 1'b1;
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (slot == '0)); // R1
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(slot)); // R2
endmodule

// File: rtl/aud_frame_shadow.sv
module aud_frame_shadow
  import aud_tx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [1:0]      fmt_sel,
  input  logic [1:0]      wlen_sel,
  input  logic            in_valid,
  input  logic [WMAX-1:0] in_left,
  input  logic [WMAX-1:0] in_right,
  output fmt_e            fmt_q,
  output pos_t            n_q,
  output logic [WMAX-1:0] left_q,
  output logic [WMAX-1:0] right_q,
  output logic            spill_q,
  output logic            underrun
);
  logic spills;

  // right word of the ending frame runs one slot past the frame
  assign spills = (right_start(fmt_q, n_q) + n_q) == pos_t'(SLOTS + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q    <= FMT_RJ;
      n_q      <= wl_bits(2'd0);
      left_q   <= '0;
      right_q  <= '0;
      spill_q  <= 1'b0;
      underrun <= 1'b0;
    end else if (frame_start) begin
      fmt_q    <= fmt_e'(fmt_sel);
      n_q      <= wl_bits(wlen_sel);
      spill_q  <= spills ? right_q[0] : 1'b0;
      underrun <= ~in_valid;
      if (in_valid) begin
        left_q  <= in_left;
        right_q <= in_right;
      end
    end
  end

  AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (underrun == !$past(in_valid))); // R10
  AST_REPEAT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !in_valid) |=> ($stable(left_q) && $stable(right_q))); // R10
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(fmt_q) && $stable(n_q))); // R9
endmodule

// File: rtl/aud_bit_mux.sv
module aud_bit_mux
  import aud_tx_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  fmt_e              fmt_q,
  input  pos_t              n_q,
  input  logic [WMAX-1:0]   left_q,
  input  logic [WMAX-1:0]   right_q,
  input  logic              spill_q,
  output logic              lrclk,
  output logic              sdata
);
  pos_t p, ls, rs;

  assign p  = {1'b0, slot};
  assign ls = left_start(fmt_q, n_q);
  assign rs = right_start(fmt_q, n_q);

  always_comb begin
    if (p >= ls && p < ls + n_q)      sdata = word_bit(left_q, n_q, p - ls);
    else if (p >= rs && p < rs + n_q) sdata = word_bit(right_q, n_q, p - rs);
    else if (slot == '0)              sdata = spill_q;
    else                              sdata = 1'b0;
  end

  assign lrclk = (fmt_q == FMT_DSP) ? (slot == '0) : slot[SLOT_W-1];
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       wlen_sel,
  input  logic             in_valid,
  input  logic [WMAX-1:0]  in_left,
  input  logic [WMAX-1:0]  in_right,
  output logic             in_ready,
  output logic             bclk,
  output logic             lrclk,
  output logic             sdata,
  output logic             underrun
);
  logic              fall_evt;
  logic              frame_start;
  logic [SLOT_W-1:0] slot;
  fmt_e              fmt_q;
  pos_t              n_q;
  logic [WMAX-1:0]   left_q, right_q;
  logic              spill_q;

  aud_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .bclk(bclk), .fall_evt(fall_evt));

  aud_slot_ctr u_slot (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .slot(slot), .frame_start(frame_start));

  aud_frame_shadow u_shadow (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .fmt_sel(fmt_sel),
    .wlen_sel(wlen_sel), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .fmt_q(fmt_q), .n_q(n_q), .left_q(left_q), .right_q(right_q), .spill_q(spill_q),
    .underrun(underrun));

  aud_bit_mux u_mux (
    .slot(slot), .fmt_q(fmt_q), .n_q(n_q), .left_q(left_q), .right_q(right_q),
    .spill_q(spill_q), .lrclk(lrclk), .sdata(sdata));

  assign in_ready = frame_start;

  AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> ($stable(sdata) && $stable(lrclk))); // R2
  AST_DSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q == FMT_DSP && slot != '0) |-> !lrclk); // R5
  AST_LEFT_HALF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_q != FMT_DSP && slot < SLOT_W'(HALF)) |-> !lrclk); // R3
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R9
endmodule

// File: tb/tb_aud_ser_tx.sv
`timescale 1ns/1ps
module tb_aud_ser_tx;
  localparam int NF = 22;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_half = 8'd2;
  logic [1:0]  fmt_sel = 2'd0, wlen_sel = 2'd0;
  logic        in_valid = 1'b0;
  logic [31:0] in_left = '0, in_right = '0;
  logic        in_ready, bclk, lrclk, sdata, underrun;

  always #2 clk = ~clk;

  aud_ser_tx #(.DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .in_valid(in_valid), .in_left(in_left), .in_right(in_right), .in_ready(in_ready),
    .bclk(bclk), .lrclk(lrclk), .sdata(sdata), .underrun(underrun));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [1:0]  fm [NF];
  logic [1:0]  fw [NF];
  bit          fv [NF];
  logic [31:0] fl [NF], fr [NF], el [NF], er [NF];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int wl_n(input logic [1:0] sel);
    return (sel == 2'd3) ? 32 : 16 + 4 * int'(sel);
  endfunction

  // kind: 0 idle slot, 1 word bit, 2 spilled right LSB
  task automatic calc(input int f, input int s, output logic b, output int kind);
    int m, n;
    logic [31:0] L, R;
    m = int'(fm[f]); n = wl_n(fw[f]); L = el[f]; R = er[f];
    b = 1'b0; kind = 0;
    if (m == 0) begin
      if (s <= 31 && (31 - s) < n) begin b = L[31 - s]; kind = 1; end
      else if (s >= 32 && (63 - s) < n) begin b = R[63 - s]; kind = 1; end
    end else if (m == 2) begin
      if (s >= 1 && s <= n) begin b = L[n - s]; kind = 1; end
      else if (s > n && s <= 2 * n) begin b = R[2 * n - s]; kind = 1; end
    end else begin
      if (s >= 1 && s <= n) begin b = L[n - s]; kind = 1; end
      else if (s >= 33 && (s - 32) <= n) begin b = R[n - (s - 32)]; kind = 1; end
    end
    if (s == 0 && f > 0 && fm[f-1] != 2'd0 && fw[f-1] == 2'd3) begin
      b = er[f-1][0]; kind = 2;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // frame table
  initial begin
    logic [31:0] pl, pr;
    pl = '0; pr = '0;
    for (int f = 0; f < NF; f++) begin
      fl[f] = 32'hA5C3_0F1E ^ (32'(f) * 32'h9E37_79B9);
      fr[f] = {fl[f][18:0], fl[f][31:19]} ^ 32'h5A5A_C3C3;
      if (f < 16) begin fm[f] = 2'(f / 4); fw[f] = 2'(f % 4); fv[f] = 1'b1; end
    end
    fm[16] = 2'd1; fw[16] = 2'd3; fv[16] = 1'b0;
    fm[17] = 2'd2; fw[17] = 2'd3; fv[17] = 1'b1;
    fm[18] = 2'd0; fw[18] = 2'd0; fv[18] = 1'b0;
    fm[19] = 2'd1; fw[19] = 2'd2; fv[19] = 1'b1;
    fm[20] = 2'd2; fw[20] = 2'd1; fv[20] = 1'b0;
    fm[21] = 2'd0; fw[21] = 2'd3; fv[21] = 1'b1;
    for (int f = 0; f < NF; f++) begin
      if (fv[f]) begin pl = fl[f]; pr = fr[f]; end
      el[f] = pl; er[f] = pr;
    end
  end

  // reset and driver
  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk(bclk == 1'b0 && sdata == 1'b0, "R11 bclk/sdata", {bclk, sdata}, 0);
    chk(underrun == 1'b0 && in_ready == 1'b0, "R11 underrun/in_ready", {underrun, in_ready}, 0);
    chk(lrclk == 1'b1, "R11 lrclk", lrclk, 1);
    for (int f = 0; f < NF; f++) begin
      fmt_sel = fm[f]; wlen_sel = fw[f]; in_valid = fv[f];
      in_left = fl[f]; in_right = fr[f];
      do @(posedge clk); while (!in_ready);
      @(negedge clk);
    end
    in_valid = 1'b0;
  end

  // monitor at falling system-clock edges
  initial begin
    int r, cyc, last_rise, pulses, slot, f, kind;
    bit pb, pready;
    logic eb, held;
    r = 0; cyc = 0; last_rise = 0; pulses = 0; pb = 1'b0; pready = 1'b0; held = 1'b0;
    wait (rst_n);
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (in_ready) begin
        pulses++;
        chk(!pready, "R9 ready pulse width", 2, 1);
      end
      pready = in_ready;
      if (bclk && pb) chk(sdata == held, "R2 sdata stable while bclk high", sdata, held);
      if (bclk && !pb) begin
        held = sdata;
        if (r > 0) begin
          chk(cyc - last_rise == 4, "R1 bclk period", 64'(cyc - last_rise), 4);
          slot = (r - 1) % 64; f = (r - 1) / 64;
          if (f >= NF) done = 1'b1;
          else begin
            calc(f, slot, eb, kind);
            if (kind == 2)      chk(sdata == eb, "R8 spilled right LSB", sdata, eb);
            else if (kind == 0) chk(sdata == 1'b0, "R7 idle slot low", sdata, 0);
            else if (fm[f] == 2'd0) chk(sdata == eb, "R4 R6 right-justified bit", sdata, eb);
            else if (fm[f] == 2'd2) chk(sdata == eb, "R5 R6 dsp-early bit", sdata, eb);
            else                    chk(sdata == eb, "R3 R6 i2s bit", sdata, eb);
            if (fm[f] == 2'd2) chk(lrclk == (slot == 0), "R5 lrclk pulse", lrclk, slot == 0);
            else if (fm[f] == 2'd0) chk(lrclk == (slot >= 32), "R4 lrclk", lrclk, slot >= 32);
            else chk(lrclk == (slot >= 32), "R3 lrclk", lrclk, slot >= 32);
            if (slot == 0) begin
              chk(underrun == !fv[f], "R10 underrun flag", underrun, !fv[f]);
              chk(pulses == f + 1, "R9 one handshake per frame", 64'(pulses), 64'(f + 1));
            end
          end
        end
        last_rise = cyc;
        r++;
      end
      pb = bclk;
    end
    summary();
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
    summary();
  end
endmodule